// File: doc/BRIEF.md
# Core Stall and Sleep Controller

This block is a single 32-bit control word for one processor core. Software writes it to freeze the core in one of three ways: park it until an interrupt arrives, hold it while a programmed cycle count runs down, or just run a countdown with no hold. The block reads back live state: the remaining count and any hold bit that has cleared itself. It drives one `stall` line to the core's fetch logic. A chip that has two cores places two copies at adjacent word offsets.

The count field is loaded by a write. While the run bit is set and the count is nonzero, the count drops by one each clock and stops at zero. There are two wait bits. When only one of them is set, either one holds the core until the count reaches zero and then stays set. When both are set, the secondary bit clears itself on the clock where the count reaches zero, and the primary bit stays set. An interrupt-pending input clears the sleep bit. An all-zero word means the core runs freely.

Top module: `core_hold_ctl`

## Requirements
- R1: After reset `rd_data` reads 0x00000000 and `stall` is low.
- R2: Bit 28 and bits 26:8 are plain storage. A write stores them and a read returns them unchanged. They never affect `stall`, and they are never altered by counting or by `irq_pend`.
- R3: While bit 31 (sleep) is set, `stall` is high. A clock edge with `irq_pend` high and no write clears bit 31, and `stall` falls in the next cycle unless a countdown hold is active.
- R4: A write with bit 31 set that coincides with `irq_pend` high leaves bit 31 clear. The wake-up is not lost.
- R5: When bit 27 (run) is set, bit 30 (primary wait) is set and the count N loaded into bits 7:0 is nonzero, `stall` is high for exactly N cycles after the write. Bits 7:0 read N, N-1, ... down to 0. After that the word still has bits 30 and 27 set.
- R6: When bits 30 and 29 are both set with run, bit 29 clears on the edge where the count goes from 1 to 0, and bit 30 stays set. Writing 0x68000080 stalls for 128 cycles and then reads 0x48000000.
- R7: Bit 29 (secondary wait) set without bit 30 holds the core like bit 30 does and stays set after the count reaches zero.
- R8: With bit 27 clear, the count in bits 7:0 does not change and `stall` stays low even if a wait bit is set.
- R9: With bit 27 set and both wait bits clear, the count still runs down to zero while `stall` stays low.
- R10: A wait bit with run set and a count of zero gives no stall.
- R11: `irq_pend` affects only bit 31. A countdown that is running continues unchanged while `irq_pend` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| irq_pend | input | 1 | Interrupt pending. Clears the sleep bit |
| stall | output | 1 | Holds the core when high |
| rd_data | output | 32 | Live readback of the control word |

## Verification
The countdown is driven with four wait-bit combinations: primary only, secondary only, both, and neither. These separate a hold that stays set, a hold that clears itself at terminal count, and a count that runs with no hold, all through the exact readback each cycle. Sleep is tested with interrupts that arrive later than the write and also in the same cycle as it. This separates a wake-up that is lost from one that is kept. Counts of zero, writes with the run bit clear, and interrupts during a countdown show that each field leaves the others alone.

// File: rtl/core_hold_ctl.sv
module core_hold_ctl #(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        irq_pend,
  output logic        stall,
  output logic [31:0] rd_data
);
  localparam int FLAG_W = 27 - CNT_W;

  logic              sleep_q, hold_q, hold_aux_q, spare_q, run_q;
  logic [FLAG_W-1:0] flag_q;
  logic [CNT_W-1:0]  cnt_q;

  wire counting = run_q & (cnt_q != '0);
  wire last     = counting & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sleep_q    <= 1'b0;
      hold_q     <= 1'b0;
      hold_aux_q <= 1'b0;
      spare_q    <= 1'b0;
      run_q      <= 1'b0;
      flag_q     <= '0;
      cnt_q      <= '0;
    end else if (wr_en) begin
      sleep_q    <= wr_data[31] & ~irq_pend;
      hold_q     <= wr_data[30];
      hold_aux_q <= wr_data[29];
      spare_q    <= wr_data[28];
      run_q      <= wr_data[27];
      flag_q     <= wr_data[26:CNT_W];
      cnt_q      <= wr_data[CNT_W-1:0];
    end else begin
      sleep_q <= sleep_q & ~irq_pend;
      if (counting) cnt_q <= cnt_q - CNT_W'(1);
      if (last && hold_q && hold_aux_q) hold_aux_q <= 1'b0;
    end
  end

  assign stall   = sleep_q | ((hold_q | hold_aux_q) & counting);
  assign rd_data = {sleep_q, hold_q, hold_aux_q, spare_q, run_q, flag_q, cnt_q};
endmodule

// File: rtl/core_hold_ctl_chk.sv
module core_hold_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        irq_pend,
  input logic        stall,
  input logic [31:0] rd_data
);
  wire run_hold = rd_data[27] & (rd_data[30] | rd_data[29]) & (rd_data[7:0] != 8'd0);

  p_sleep_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] |-> stall);
  p_irq_wakes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !wr_en) |=> !rd_data[31]);
  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_data[27] && rd_data[7:0] != 8'd0) |=> rd_data[7:0] == $past(rd_data[7:0]) - 8'd1);
  p_hold_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_hold |-> stall);
  p_no_stall_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[31] && !run_hold) |-> !stall);
  p_no_run_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_data[27]) |=> $stable(rd_data[7:0]));
  p_flags_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[28:8]));
  p_dual_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_data[30] && rd_data[29] && rd_data[27] && rd_data[7:0] == 8'd1)
      |=> (!rd_data[29] && rd_data[30]));
endmodule

bind core_hold_ctl core_hold_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq_pend(irq_pend),
  .stall(stall), .rd_data(rd_data)
);

// File: tb/core_hold_ctl_bench.sv
module core_hold_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic irq_pend = 1'b0;
  logic stall;
  logic [31:0] rd_data;

  always #4 clk = ~clk;

  core_hold_ctl u_core_hold_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .irq_pend(irq_pend), .stall(stall), .rd_data(rd_data)
  );

  typedef struct {
    logic [31:0] rd;
    logic        st;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic cyc(input logic w, input logic [31:0] d, input logic irq,
                     input logic [31:0] exp_rd, input logic exp_st, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = w; wr_data = d; irq_pend = irq;
    e.rd = exp_rd; e.st = exp_st; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rd_data !== e.rd || stall !== e.st) begin
        errors++;
        $display("FAIL %s: rd=%08h stall=%0b expected rd=%08h stall=%0b",
                 e.tag, rd_data, stall, e.rd, e.st);
      end
    end
  end

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cyc(0, 0, 0, 32'h0, 0, "R1");
    // R2 storage only
    cyc(1, 32'h15A5C300, 0, 32'h15A5C300, 0, "R2");
    cyc(0, 0, 0, 32'h15A5C300, 0, "R2");
    cyc(0, 0, 1, 32'h15A5C300, 0, "R2");
    // R3 sleep until irq
    cyc(1, 32'h80001200, 0, 32'h80001200, 1, "R3");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 32'h80001200, 1, "R3");
    cyc(0, 0, 1, 32'h00001200, 0, "R3");
    cyc(0, 0, 0, 32'h00001200, 0, "R3");
    // R4 irq with sleep write
    cyc(1, 32'h80000000, 1, 32'h0, 0, "R4");
    cyc(0, 0, 0, 32'h0, 0, "R4");
    // R5 primary wait, count 3
    cyc(1, 32'h48000003, 0, 32'h48000003, 1, "R5");
    cyc(0, 0, 0, 32'h48000002, 1, "R5");
    cyc(0, 0, 0, 32'h48000001, 1, "R5");
    cyc(0, 0, 0, 32'h48000000, 0, "R5");
    cyc(0, 0, 0, 32'h48000000, 0, "R5");
    // R6 both waits, 128 cycles
    cyc(1, 32'h68000080, 0, 32'h68000080, 1, "R6");
    for (int k = 1; k < 128; k++) cyc(0, 0, 0, 32'h68000000 | (128 - k), 1, "R6");
    cyc(0, 0, 0, 32'h48000000, 0, "R6");
    cyc(0, 0, 0, 32'h48000000, 0, "R6");
    // R7 secondary wait alone
    cyc(1, 32'h28000005, 0, 32'h28000005, 1, "R7");
    for (int k = 1; k < 5; k++) cyc(0, 0, 0, 32'h28000000 | (5 - k), 1, "R7");
    cyc(0, 0, 0, 32'h28000000, 0, "R7");
    // R8 no run bit
    cyc(1, 32'h60000010, 0, 32'h60000010, 0, "R8");
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 32'h60000010, 0, "R8");
    // R9 run without wait
    cyc(1, 32'h08000004, 0, 32'h08000004, 0, "R9");
    for (int k = 1; k <= 4; k++) cyc(0, 0, 0, 32'h08000000 | (4 - k), 0, "R9");
    cyc(0, 0, 0, 32'h08000000, 0, "R9");
    // R10 zero count
    cyc(1, 32'h68000000, 0, 32'h68000000, 0, "R10");
    cyc(0, 0, 0, 32'h68000000, 0, "R10");
    // R11 irq during countdown
    cyc(1, 32'h4800A304, 0, 32'h4800A304, 1, "R11");
    for (int k = 1; k < 4; k++) cyc(0, 0, 1, 32'h4800A300 | (4 - k), 1, "R11");
    cyc(0, 0, 1, 32'h4800A300, 0, "R11");
    cyc(0, 0, 0, 32'h4800A300, 0, "R11");
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule